// File: doc/BRIEF.md
# Two-Channel External Interrupt Sense Unit

This block turns asynchronous external pins into interrupt requests. A single 8-bit control byte selects the sense mode for each of two channels. A mode field is two bits wide, and its four codes are: low level, any change, falling edge and rising edge. Each pin is first brought into the clock domain by a two-flop synchronizer that resets to logic high. An edge detector then compares the synchronized value with a copy delayed by one cycle.

The three edge-type modes (any change, falling, rising) latch a sensed edge in a per-channel pending flag. The flag is set whatever the mask says, and a one-cycle acknowledge pulse clears it. Low-level mode does not latch: its request follows the synchronized pin and falls as soon as the pin returns high. A channel's request reaches its output only while the global interrupt enable and that channel's mask bit are both high.

Software writes the control byte through a plain write strobe with write data, and reads it back on a read-data output. The interface has no handshake, because a write always completes in the cycle in which it is presented.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the control byte reads 0x00, both channels are in low-level mode, no flag is pending and both request outputs are low.
- R2: Control bits 7:4 always read as zero, and writing them has no effect on the byte that is read back.
- R3: Control bits 1:0 hold the mode of channel 0 and bits 3:2 hold the mode of channel 1. A write takes effect on the next rising clock edge and is visible on the read-data output from then on.
- R4: Mode code 00 (low level): the request is high while the synchronized pin is low, with two cycles of latency from the pin. It drops two cycles after the pin returns high, with no latching.
- R5: Mode code 01 (any change): every rising or falling transition of the pin sets the pending flag. The request rises three cycles after the pin transition.
- R6: Mode code 10 (falling edge): only a high-to-low transition sets the pending flag. A rising transition has no effect.
- R7: Mode code 11 (rising edge): only a low-to-high transition sets the pending flag. A falling transition has no effect.
- R8: A request output is high only while the global enable and the channel's mask bit are both high. An edge sensed while the channel is masked still sets the pending flag, and that flag appears at the output once the channel is unmasked.
- R9: A one-cycle acknowledge clears the pending flag. If a new edge is sensed in the same cycle as the acknowledge, the flag stays set.
- R10: A write that changes a channel's mode clears that channel's pending flag. Neither the mode change nor an edge sensed in the same cycle leaves a flag set.
- R11: In every edge-type mode, a pin pulse lasting two clock periods produces a pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the control byte |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Control byte read-back |
| irq_global_en | input | 1 | Global interrupt enable |
| irq_mask | input | 2 | Per-channel mask, where 1 lets the request through |
| ext_pin | input | 2 | Asynchronous external pins |
| irq_ack | input | 2 | Per-channel acknowledge pulse |
| irq_req | output | 2 | Gated per-channel interrupt request |

## Verification
The assertions assume that the write data, the acknowledge and the mask are known values whenever they are sampled. They also assume that the pins are binary once the synchronizer has sampled them. They make no assumption about how long a pin pulse lasts, and an acknowledge may arrive in any cycle, including one in which an edge is sensed or the mode changes. The stimulus drives every input on the falling clock edge and only with 0 or 1, so none of these assumptions is broken. It deliberately includes acknowledges that collide with edges, mode writes that coincide with edges, and pin pulses as short as one cycle.

// File: rtl/eis_pkg.sv
package eis_pkg;
  localparam int FIELD_W = 2;

  typedef enum logic [FIELD_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eis_ctrl_reg.sv
module eis_ctrl_reg
  import eis_pkg::*;
#(
  parameter int CH    = 2,
  parameter int REG_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic [REG_W-1:0]      rdata_o,
  output logic [CH*FIELD_W-1:0] modes_o,
  output logic [CH-1:0]         chg_o
);
  localparam int USED_W = CH * FIELD_W;

  logic [USED_W-1:0] modes_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       modes_q <= '0;
    else if (wr_en_i) modes_q <= wdata_i[USED_W-1:0];
  end

  for (genvar i = 0; i < CH; i++) begin : g_chg
    assign chg_o[i] = wr_en_i &&
      (wdata_i[i*FIELD_W +: FIELD_W] != modes_q[i*FIELD_W +: FIELD_W]);
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[USED_W-1:0] = modes_q;
  end

  assign modes_o = modes_q;

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[REG_W-1:USED_W] == '0);

  a_r3_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> rdata_o[USED_W-1:0] == $past(wdata_i[USED_W-1:0]));
endmodule

// File: rtl/eis_channel.sv
module eis_channel
  import eis_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_i,
  input  sense_e mode_i,
  input  logic   chg_i,
  input  logic   ack_i,
  output logic   pend_o,
  output logic   lvl_o
);
  logic pin_s, prev_q, pend_q;
  logic rise, fall, hit;

  eis_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pin_i),
    .q_o  (pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_s;
  end

  always_comb begin
    rise = pin_s & ~prev_q;
    fall = ~pin_s & prev_q;
    unique case (mode_i)
      SENSE_ANY:  hit = rise | fall;
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (chg_i) pend_q <= 1'b0;
    else if (hit)   pend_q <= 1'b1;
    else if (ack_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign lvl_o  = (mode_i == SENSE_LOW) & ~pin_s;

  a_r4_low_never_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SENSE_LOW) |-> !pend_q);

  a_r7_rise_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SENSE_RISE && pin_s && !prev_q && !chg_i) |=> pend_q);

  a_r6_fall_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SENSE_FALL && !pin_s && prev_q && !chg_i) |=> pend_q);

  a_r9_edge_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && hit && !chg_i) |=> pend_q);

  a_r10_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    chg_i |=> !pend_q);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int CH          = 2,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             irq_global_en,
  input  logic [CH-1:0]    irq_mask,
  input  logic [CH-1:0]    ext_pin,
  input  logic [CH-1:0]    irq_ack,
  output logic [CH-1:0]    irq_req
);
  logic [CH*FIELD_W-1:0] modes;
  logic [CH-1:0]         chg, pend, lvl;

  eis_ctrl_reg #(.CH(CH), .REG_W(REG_W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en_i(cfg_wr_en),
    .wdata_i(cfg_wdata),
    .rdata_o(cfg_rdata),
    .modes_o(modes),
    .chg_o  (chg)
  );

  for (genvar i = 0; i < CH; i++) begin : g_ch
    sense_e mode_i;
    assign mode_i = sense_e'(modes[i*FIELD_W +: FIELD_W]);

    eis_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (ext_pin[i]),
      .mode_i(mode_i),
      .chg_i (chg[i]),
      .ack_i (irq_ack[i]),
      .pend_o(pend[i]),
      .lvl_o (lvl[i])
    );

    assign irq_req[i] = irq_global_en & irq_mask[i] & (pend[i] | lvl[i]);
  end

  a_r8_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_global_en |-> irq_req == '0);

  a_r8_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~irq_mask) == '0);
endmodule

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       irq_global_en = 1'b0;
  logic [1:0] irq_mask = '0;
  logic [1:0] ext_pin = 2'b11;
  logic [1:0] irq_ack = '0;
  logic [1:0] irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ext_irq_sense u_ext_irq_sense (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_global_en(irq_global_en), .irq_mask(irq_mask),
    .ext_pin(ext_pin), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  // Behavioural reference: pin history queue (newest first) and per-channel state.
  logic [1:0] hist[$];
  int         m_mode[2];
  bit         m_pend[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{2'b11, 2'b11, 2'b11};
      m_mode[0] = 0; m_mode[1] = 0;
      m_pend[0] = 0; m_pend[1] = 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit cur, old, ev, changed;
        int nf;
        cur = hist[1][c];
        old = hist[2][c];
        ev = (m_mode[c] == 1 && cur != old) ||
             (m_mode[c] == 2 && !cur && old) ||
             (m_mode[c] == 3 && cur && !old);
        nf = int'(cfg_wdata[2*c +: 2]);
        changed = cfg_wr_en && (nf != m_mode[c]);
        if (changed)         m_pend[c] = 0;
        else if (ev)         m_pend[c] = 1;
        else if (irq_ack[c]) m_pend[c] = 0;
      end
      hist.push_front(ext_pin);
      void'(hist.pop_back());
      if (cfg_wr_en) begin
        m_mode[0] = int'(cfg_wdata[1:0]);
        m_mode[1] = int'(cfg_wdata[3:2]);
      end
    end
  end

  function automatic string mode_tag(int m);
    case (m)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Cycle compare against the reference, sampled 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [7:0] exp_rd;
      exp_rd = {4'b0000, 2'(m_mode[1]), 2'(m_mode[0])};
      checks++;
      if (cfg_rdata !== exp_rd) begin
        errors++;
        $display("FAIL R3 readback: actual %h expected %h", cfg_rdata, exp_rd);
      end
      for (int c = 0; c < 2; c++) begin
        bit e;
        e = irq_global_en && irq_mask[c] &&
            ((m_mode[c] == 0) ? !hist[1][c] : m_pend[c]);
        checks++;
        if (irq_req[c] !== e) begin
          errors++;
          $display("FAIL %s ch%0d request (R8 gating): actual %b expected %b",
                   mode_tag(m_mode[c]), c, irq_req[c], e);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    cfg_wr_en = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic ack(input int c);
    irq_ack[c] = 1'b1;
    @(negedge clk);
    irq_ack[c] = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 reset readback", cfg_rdata, 8'h00);
    irq_global_en = 1'b1; irq_mask = 2'b11; #1;
    chk("R1 no request after reset", {6'b0, irq_req}, 8'h00);
    @(negedge clk);

    // R2 reserved bits
    wr(8'hF5);
    chk("R2 reserved ignored", cfg_rdata, 8'h05);
    // R3 field placement
    wr(8'h0D);
    chk("R3 field placement", cfg_rdata, 8'h0D);

    // R4 low level, not latched
    wr(8'h00);
    ext_pin[0] = 1'b0;
    idle(1);
    chk("R4 latency not yet", {7'b0, irq_req[0]}, 8'h00);
    idle(1);
    chk("R4 level request", {7'b0, irq_req[0]}, 8'h01);
    ext_pin[0] = 1'b1;
    idle(2);
    chk("R4 not latched", {7'b0, irq_req[0]}, 8'h00);

    // R7 rising only on ch1
    wr(8'h0C);
    ext_pin[1] = 1'b0;
    idle(3);
    chk("R7 falling ignored", {7'b0, irq_req[1]}, 8'h00);
    ext_pin[1] = 1'b1;
    idle(3);
    chk("R7 rising captured", {7'b0, irq_req[1]}, 8'h01);
    ack(1);
    chk("R9 ack clears", {7'b0, irq_req[1]}, 8'h00);

    // R6 falling only on ch0
    wr(8'h0E);
    ext_pin[0] = 1'b0;
    idle(3);
    chk("R6 falling captured", {7'b0, irq_req[0]}, 8'h01);
    ack(0);
    ext_pin[0] = 1'b1;
    idle(3);
    chk("R6 rising ignored", {7'b0, irq_req[0]}, 8'h00);

    // R5 any change on ch0
    wr(8'h0D);
    ext_pin[0] = 1'b0;
    idle(3);
    chk("R5 fall edge", {7'b0, irq_req[0]}, 8'h01);
    ack(0);
    ext_pin[0] = 1'b1;
    idle(3);
    chk("R5 rise edge", {7'b0, irq_req[0]}, 8'h01);
    ack(0);

    // R8 masked edge still pends
    irq_mask = 2'b10;
    ext_pin[0] = 1'b0;
    idle(3);
    chk("R8 masked output", {7'b0, irq_req[0]}, 8'h00);
    irq_mask = 2'b11; #1;
    chk("R8 unmasked pending", {7'b0, irq_req[0]}, 8'h01);
    irq_global_en = 1'b0; #1;
    chk("R8 global off", {6'b0, irq_req}, 8'h00);
    irq_global_en = 1'b1;
    @(negedge clk);

    // R9 edge in ack cycle keeps flag (pending still set on ch0)
    ext_pin[0] = 1'b1;
    idle(2);
    irq_ack[0] = 1'b1;
    @(negedge clk);
    irq_ack[0] = 1'b0;
    chk("R9 edge beats ack", {7'b0, irq_req[0]}, 8'h01);
    ack(0);
    chk("R9 later ack clears", {7'b0, irq_req[0]}, 8'h00);

    // R10 mode change clears pending
    ext_pin[0] = 1'b0;
    idle(3);
    wr(8'h0E);
    chk("R10 change clears", {7'b0, irq_req[0]}, 8'h00);
    wr(8'h0C);
    idle(1);
    chk("R10 low level active", {7'b0, irq_req[0]}, 8'h01);
    wr(8'h0E);
    idle(3);
    chk("R10 no spurious edge", {7'b0, irq_req[0]}, 8'h00);

    // R11 two-cycle pulses
    ext_pin[0] = 1'b1; ext_pin[1] = 1'b0;
    idle(4);
    ext_pin[1] = 1'b1; ext_pin[0] = 1'b0;
    idle(2);
    ext_pin[1] = 1'b0; ext_pin[0] = 1'b1;
    idle(3);
    chk("R11 short pulses caught", {6'b0, irq_req}, 8'h03);
    ack(0); ack(1);

    // Mixed stimulus against the reference model
    for (int i = 0; i < 3000; i++) begin
      for (int c = 0; c < 2; c++) begin
        if ($urandom_range(3) == 0) ext_pin[c] = ~ext_pin[c];
        irq_ack[c] = ($urandom_range(5) == 0);
      end
      cfg_wr_en = ($urandom_range(29) == 0);
      cfg_wdata = 8'($urandom);
      if ($urandom_range(39) == 0) irq_mask = 2'($urandom);
      if ($urandom_range(59) == 0) irq_global_en = ~irq_global_en;
      @(negedge clk);
    end
    cfg_wr_en = 1'b0; irq_ack = '0;
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule